// File: doc/BRIEF.md
# Quad-Node Heap Memory with Rotation

The block is a heap store in which every memory word holds four nodes. Each node still has its own address. An access at any node address covers four consecutive nodes that start at that address, whether or not the address is aligned to a word. Inside the block, the address is split into a word index and a two-bit lane offset, and four node-wide banks are addressed separately. Bank `k` holds every node whose address modulo four equals `k`. A bank whose number is below the offset reads or writes the following word. Rotators on the write and read data paths move each node into its proper place.

A write carries a count of one to four nodes, so nodes past the count keep their values. A read is registered twice: once at the bank outputs and once after rotation. Data therefore appears two clock edges after the request, and one read can be issued on every cycle. Accesses that run past the last node continue at node 0.

Top module: `qheap`

## Requirements
- R1: While `rst_ni` is low, and until the first read completes, `rvalid_o` is 0 and `rdata_o` is 0.
- R2: A read at node address A returns node A+j in lane j, with lane j at bits `[j*NODE_W +: NODE_W]` of `rdata_o`, for j = 0..3 and any A, aligned or not.
- R3: `rvalid_o` is high in the cycle that follows the second rising edge after a sampled `rd_i`, and low otherwise. Back-to-back reads return one result per cycle, in request order.
- R4: `wcnt_i` holds the node count minus one (0 means one node, 3 means four). A write stores lane j of `wdata_i` to node A+j for every j <= `wcnt_i`.
- R5: A write leaves every node outside A..A+`wcnt_i` unchanged, and this includes the nodes of the same words that lie beyond the count.
- R6: Node addresses wrap modulo 2^`ADDR_W`, so an access near the top continues at node 0 for both reads and writes.
- R7: When `rd_i` and `wr_i` are high in the same cycle, the read returns the contents from before that write.
- R8: `rdata_o` holds its value in every cycle in which no read completes.
- R9: In a write cycle exactly `wcnt_i`+1 banks are write-enabled. With no write, no bank is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Node address of the first node of the access |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| wcnt_i | input | 2 | Write node count minus one |
| wdata_i | input | 4*NODE_W | Write nodes, lane 0 goes to addr_i |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 4*NODE_W | Read nodes, lane 0 is the node at the requested address |

## Verification
Read results fall due two rising edges after the edge that samples `rd_i`. The bench drives `rd_i` on a falling edge and compares `rvalid_o` and `rdata_o` on the falling edge that follows the second rising edge. It also confirms that `rvalid_o` is still low one falling edge earlier. Writes take effect at the edge that samples them, so a write is checked by a later read of the nodes it covered and the nodes around them. For back-to-back and mixed read-write cycles, the expected lanes are taken from the bench's node model at the cycle each request was issued, and each result is compared in its own due cycle.

// File: rtl/qheap_pkg.sv
package qheap_pkg;
  localparam int LANES = 4;
  localparam int OFF_W = $clog2(LANES);
endpackage

// File: rtl/qheap_split.sv
module qheap_split
  import qheap_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int WORD_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic                              wr_i,
  input  logic [OFF_W-1:0]                  wcnt_i,
  output logic [LANES-1:0][WORD_W-1:0]      bank_addr_o,
  output logic [LANES-1:0][OFF_W-1:0]       bank_lane_o,
  output logic [LANES-1:0]                  bank_we_o
);
  logic [WORD_W-1:0] word;
  logic [OFF_W-1:0]  off;
  assign word = addr_i[ADDR_W-1:OFF_W];
  assign off  = addr_i[OFF_W-1:0];

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    // banks below the offset hold nodes of the next word
    assign bank_addr_o[k] = word + WORD_W'(OFF_W'(k) < off);
    assign bank_lane_o[k] = OFF_W'(k) - off;
    assign bank_we_o[k]   = wr_i && (bank_lane_o[k] <= wcnt_i);
  end
endmodule

// File: rtl/qheap_bank.sv
module qheap_bank #(
  parameter int NODE_W = 16,
  parameter int WORD_W = 6,
  localparam int DEPTH = 1 << WORD_W
) (
  input  logic              clk_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic              re_i,
  input  logic              we_i,
  input  logic [NODE_W-1:0] wd_i,
  output logic [NODE_W-1:0] rd_o
);
  logic [NODE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wd_i;
    if (re_i) rd_o <= mem[addr_i];
  end
endmodule

// File: rtl/qheap_rotate.sv
module qheap_rotate
  import qheap_pkg::*;
#(
  parameter int NODE_W = 16
) (
  input  logic [LANES-1:0][NODE_W-1:0] bank_i,
  input  logic [OFF_W-1:0]             off_i,
  output logic [LANES-1:0][NODE_W-1:0] lane_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [OFF_W-1:0] src;
    assign src       = OFF_W'(j) + off_i;
    assign lane_o[j] = bank_i[src];
  end
endmodule

// File: rtl/qheap.sv
module qheap
  import qheap_pkg::*;
#(
  parameter int NODE_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic [1:0]              wcnt_i,
  input  logic [4*NODE_W-1:0]     wdata_i,
  output logic                    rvalid_o,
  output logic [4*NODE_W-1:0]     rdata_o
);
  localparam int WORD_W = ADDR_W - OFF_W;

  logic [LANES-1:0][WORD_W-1:0] bank_addr;
  logic [LANES-1:0][OFF_W-1:0]  bank_lane;
  logic [LANES-1:0]             bank_we;
  logic [LANES-1:0][NODE_W-1:0] bank_rd;
  logic [LANES-1:0][NODE_W-1:0] rot;
  logic                         rd_q;
  logic [OFF_W-1:0]             off_q;

  qheap_split #(.ADDR_W(ADDR_W)) u_split (
    .addr_i      (addr_i),
    .wr_i        (wr_i),
    .wcnt_i      (wcnt_i),
    .bank_addr_o (bank_addr),
    .bank_lane_o (bank_lane),
    .bank_we_o   (bank_we)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    logic [NODE_W-1:0] wd;
    assign wd = wdata_i[bank_lane[k]*NODE_W +: NODE_W];
    qheap_bank #(.NODE_W(NODE_W), .WORD_W(WORD_W)) u_bank (
      .clk_i  (clk_i),
      .addr_i (bank_addr[k]),
      .re_i   (rd_i),
      .we_i   (bank_we[k]),
      .wd_i   (wd),
      .rd_o   (bank_rd[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      off_q <= '0;
    end else begin
      rd_q  <= rd_i;
      if (rd_i) off_q <= addr_i[OFF_W-1:0];
    end
  end

  qheap_rotate #(.NODE_W(NODE_W)) u_rot (
    .bank_i (bank_rd),
    .off_i  (off_q),
    .lane_o (rot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_q;
      if (rd_q) rdata_o <= rot;
    end
  end
endmodule

// File: rtl/qheap_chk.sv
module qheap_chk #(
  parameter int NODE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              wr_i,
  input logic [1:0]        wcnt_i,
  input logic [3:0]        bank_we,
  input logic              rd_q,
  input logic              rvalid_o,
  input logic [4*NODE_W-1:0] rdata_o
);
  a_r3_valid_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> ##2 rvalid_o);
  a_r3_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_q |=> !rvalid_o);
  a_r8_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_q |=> $stable(rdata_o));
  a_r9_we_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> $countones(bank_we) == 32'(wcnt_i) + 1);
  a_r9_no_we_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |-> bank_we == '0);
endmodule

bind qheap qheap_chk #(.NODE_W(NODE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_i     (rd_i),
  .wr_i     (wr_i),
  .wcnt_i   (wcnt_i),
  .bank_we  (bank_we),
  .rd_q     (rd_q),
  .rvalid_o (rvalid_o),
  .rdata_o  (rdata_o)
);

// File: tb/tb_qheap.sv
module tb_qheap;
  localparam int NODE_W = 16;
  localparam int ADDR_W = 8;
  localparam int NODES  = 1 << ADDR_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic rd_i = 1'b0, wr_i = 1'b0;
  logic [1:0] wcnt_i = '0;
  logic [4*NODE_W-1:0] wdata_i = '0;
  logic rvalid_o;
  logic [4*NODE_W-1:0] rdata_o;

  always #10 clk_i = ~clk_i;

  qheap #(.NODE_W(NODE_W), .ADDR_W(ADDR_W)) dut (.*);

  logic [NODE_W-1:0] model [NODES];
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  function automatic logic [4*NODE_W-1:0] expect_rd(input int a);
    logic [4*NODE_W-1:0] v;
    for (int j = 0; j < 4; j++) v[j*NODE_W +: NODE_W] = model[(a + j) % NODES];
    return v;
  endfunction

  task automatic chk(input string req, input logic [4*NODE_W-1:0] act, input logic [4*NODE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input int a, input int c, input logic [4*NODE_W-1:0] d);
    @(negedge clk_i);
    addr_i = ADDR_W'(a); wr_i = 1'b1; wcnt_i = 2'(c); wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
    for (int j = 0; j <= c; j++) model[(a + j) % NODES] = d[j*NODE_W +: NODE_W];
  endtask

  task automatic do_rd(input int a, input string req);
    logic [4*NODE_W-1:0] e;
    e = expect_rd(a);
    @(negedge clk_i);
    addr_i = ADDR_W'(a); rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    chk("R3 early", 64'(rvalid_o), 64'd0);
    @(negedge clk_i);
    chk("R3 valid", 64'(rvalid_o), 64'd1);
    chk(req, rdata_o, e);
  endtask

  function automatic logic [4*NODE_W-1:0] rnd_data();
    return {$urandom(), $urandom()};
  endfunction

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4*NODE_W-1:0] held, e0, e1, d;
    void'($urandom(32'd4242));
    #5;
    chk("R1 rvalid reset", 64'(rvalid_o), 64'd0);
    chk("R1 rdata reset", rdata_o, '0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 rvalid after reset", 64'(rvalid_o), 64'd0);
    chk("R1 rdata after reset", rdata_o, '0);

    // fill every node, aligned four-node writes (R4)
    for (int w = 0; w < NODES; w += 4) do_wr(w, 3, rnd_data());
    for (int a = 0; a < 8; a++) do_rd(a, "R2 unaligned read");

    // partial write in middle of words, neighbours must survive
    do_wr(37, 1, {16'hdead, 16'hbeef, 16'h1111, 16'h2222});
    do_rd(36, "R4 R5 partial write");
    do_rd(39, "R5 neighbour after partial");
    do_wr(50, 0, 64'h0000_0000_0000_abcd);
    do_rd(48, "R5 single node write");

    // wrap at the top
    do_wr(NODES - 2, 3, 64'h4444_3333_2222_1111);
    do_rd(NODES - 3, "R6 wrap read");
    do_rd(0, "R6 wrap write landed at 0");

    // back-to-back reads
    e0 = expect_rd(10); e1 = expect_rd(203);
    @(negedge clk_i); addr_i = 8'd10; rd_i = 1'b1;
    @(negedge clk_i); addr_i = 8'd203;
    @(negedge clk_i); rd_i = 1'b0;
    chk("R3 pipelined first", rdata_o, e0);
    @(negedge clk_i);
    chk("R3 pipelined second", rdata_o, e1);
    chk("R3 pipelined valid", 64'(rvalid_o), 64'd1);

    // read and write in the same cycle
    e0 = expect_rd(21);
    @(negedge clk_i);
    addr_i = 8'd21; rd_i = 1'b1; wr_i = 1'b1; wcnt_i = 2'd3; d = rnd_data(); wdata_i = d;
    @(negedge clk_i);
    rd_i = 1'b0; wr_i = 1'b0;
    for (int j = 0; j < 4; j++) model[21 + j] = d[j*NODE_W +: NODE_W];
    @(negedge clk_i);
    chk("R7 read before write", rdata_o, e0);
    do_rd(21, "R7 write then visible");

    // hold
    held = rdata_o;
    do_wr(100, 2, rnd_data());
    repeat (3) @(negedge clk_i);
    chk("R8 rdata hold", rdata_o, held);
    chk("R3 idle no valid", 64'(rvalid_o), 64'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 1) == 0)
        do_wr($urandom_range(0, NODES - 1), $urandom_range(0, 3), rnd_data());
      else
        do_rd($urandom_range(0, NODES - 1), "R2 R4 R5 R6 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule